// File: doc/BRIEF.md
# Reversible Up/Down LFSR Counter

This block is a 16-bit linear-feedback shift-register counter that can walk its pseudo-random sequence in either direction. On each enabled clock it takes one step: forward (shift toward bit 0 with a new bit fed into the top) or backward (shift toward the top with a new bit fed into bit 0). A backward step rebuilds the bit that the matching forward step discarded. As a result, any forward run can be undone exactly, one state at a time.

The direction input is sampled on every clock, so a consumer such as a ranging or address-walking circuit can move back and forth through the sequence freely. A load strobe with a data word seeds the register. A parameter selects XOR or XNOR feedback. Each flavour has one state that it can never leave, and the user must never seed that state.

Top module: `lfsr_rev_counter`

## Requirements
- R1: After reset the state output equals the SEED parameter (default 16'hACE1).
- R2: When load_i is high at a clock edge, the state takes load_val_i at that edge, whatever enable_i and dir_i are.
- R3: When load_i and enable_i are both low, the state does not change, whatever dir_i is.
- R4: A forward step (enable_i=1, dir_i=1) moves bit i+1 into bit i for i=0..14. Bit 15 becomes bit12 ^ bit3 ^ bit1 ^ bit0 of the old state (XOR flavour).
- R5: A reverse step (enable_i=1, dir_i=0) moves bit i-1 into bit i for i=1..15. Bit 0 becomes bit15 ^ bit11 ^ bit2 ^ bit0 of the old state (XOR flavour).
- R6: From any state, N forward steps followed by N reverse steps visit the forward states in exact reverse order and end on the starting state.
- R7: dir_i may change on any cycle. A forward step followed at once by a reverse step, or a reverse step followed by a forward step, restores the original state.
- R8: With INVERT=1 both feedback bits of R4 and R5 are complemented (XNOR), and R6 and R7 still hold.
- R9: The lock state (all zeros for XOR, all ones for XNOR) is never entered from any other state by stepping, and once loaded it stays there under stepping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset to SEED |
| enable_i | input | 1 | Take one step this cycle |
| dir_i | input | 1 | 1 = forward step, 0 = reverse step |
| load_i | input | 1 | Load strobe, has priority over enable_i |
| load_val_i | input | 16 | Value written on load |
| state_o | output | 16 | Current register contents |

## Verification
The state register is the output, so a wrong tap or a wrong mux leg shows on state_o on the edge after the faulty step. A fault that only touches the regenerated bit stays hidden on forward runs. It shows up when a reverse walk departs from the recorded forward states, at the first step that reads the faulty tap. For that reason the round-trip scenarios compare every state, not just the end point. A lost hold or a wrong load priority shows on the next edge.

// File: rtl/lfsr_rev_pkg.sv
package lfsr_rev_pkg;

  // Step direction as seen on the dir_i pin
  typedef enum logic {
    STEP_BACK = 1'b0,
    STEP_FWD  = 1'b1
  } step_dir_e;

  // Next-state source chosen at the register
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_STEP = 2'd1,
    SRC_LOAD = 2'd2
  } state_src_e;

endpackage

// File: rtl/lfsr_rev_fb.sv
module lfsr_rev_fb #(
  parameter int unsigned     WIDTH  = 16,
  parameter logic [WIDTH-1:0] MASK  = '0,
  parameter bit              INVERT = 1'b0
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             bit_o
);

  // One-bit sum of the tapped positions, optionally complemented
  always_comb begin
    bit_o = (^(vec_i & MASK)) ^ INVERT;
  end

endmodule

// File: rtl/lfsr_rev_next.sv
module lfsr_rev_next
  import lfsr_rev_pkg::*;
#(
  parameter int unsigned      WIDTH    = 16,
  parameter logic [WIDTH-1:0] FWD_TAPS = 16'h100B,
  parameter bit               INVERT   = 1'b0
) (
  input  logic [WIDTH-1:0] cur_i,
  input  step_dir_e        dir_i,
  output logic [WIDTH-1:0] nxt_o
);

  // The reverse taps are the forward taps moved one place toward bit 0.
  // The length tap at bit 0 falls away, and the top bit (the last inserted
  // bit) takes its place.
  localparam logic [WIDTH-1:0] TOP_BIT  = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] REV_TAPS = (FWD_TAPS >> 1) | TOP_BIT;

  logic fb_fwd;
  logic fb_rev;

  lfsr_rev_fb #(
    .WIDTH (WIDTH),
    .MASK  (FWD_TAPS),
    .INVERT(INVERT)
  ) u_fb_fwd (
    .vec_i(cur_i),
    .bit_o(fb_fwd)
  );

  lfsr_rev_fb #(
    .WIDTH (WIDTH),
    .MASK  (REV_TAPS),
    .INVERT(INVERT)
  ) u_fb_rev (
    .vec_i(cur_i),
    .bit_o(fb_rev)
  );

  // One two-way mux per flip-flop, choosing between its two neighbours
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic from_up;
    logic from_down;
    if (i == WIDTH - 1) begin : g_top
      assign from_up   = fb_fwd;
      assign from_down = cur_i[i-1];
    end else if (i == 0) begin : g_bot
      assign from_up   = cur_i[i+1];
      assign from_down = fb_rev;
    end else begin : g_mid
      assign from_up   = cur_i[i+1];
      assign from_down = cur_i[i-1];
    end
    assign nxt_o[i] = (dir_i == STEP_FWD) ? from_up : from_down;
  end

endmodule

// File: rtl/lfsr_rev_counter.sv
module lfsr_rev_counter
  import lfsr_rev_pkg::*;
#(
  parameter int unsigned       WIDTH    = 16,
  parameter logic [WIDTH-1:0]  FWD_TAPS = 16'h100B,
  parameter bit                INVERT   = 1'b0,
  parameter logic [WIDTH-1:0]  SEED     = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             dir_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic [WIDTH-1:0] state_o
);

  localparam logic [WIDTH-1:0] LOCK_STATE = INVERT ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] step_val;
  state_src_e       src_sel;
  step_dir_e        dir_e;

  assign dir_e = step_dir_e'(dir_i);

  lfsr_rev_next #(
    .WIDTH   (WIDTH),
    .FWD_TAPS(FWD_TAPS),
    .INVERT  (INVERT)
  ) u_next (
    .cur_i(state_q),
    .dir_i(dir_e),
    .nxt_o(step_val)
  );

  // Load wins over stepping
  always_comb begin
    if (load_i)        src_sel = SRC_LOAD;
    else if (enable_i) src_sel = SRC_STEP;
    else               src_sel = SRC_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else begin
      unique case (src_sel)
        SRC_LOAD: state_q <= load_val_i;
        SRC_STEP: state_q <= step_val;
        default:  state_q <= state_q;
      endcase
    end
  end

  assign state_o = state_q;

  // R1: the first cycle out of reset shows the seed
  p_reset_seed_r1: assert property (@(posedge clk)
    !rst_n |=> state_q == SEED);

  // R2: load takes effect on the next edge
  p_load_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> state_q == $past(load_val_i));

  // R3: no load, no enable means no change
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !enable_i) |=> $stable(state_q));

  // R4: forward step moves every bit one place toward bit 0
  p_fwd_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && enable_i && dir_i) |=> state_q[WIDTH-2:0] == $past(state_q[WIDTH-1:1]));

  // R5: reverse step moves every bit one place toward the top
  p_rev_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && enable_i && !dir_i) |=> state_q[WIDTH-1:1] == $past(state_q[WIDTH-2:0]));

  // R7: a forward step bounced back at once restores the state
  p_bounce_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && enable_i && dir_i) ##1 (!load_i && enable_i && !dir_i)
      |=> state_q == $past(state_q, 2));

  // R9: stepping never enters the lock state from outside it
  p_no_lock_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && state_q != LOCK_STATE) |=> state_q != LOCK_STATE);

  // R9: the lock state is a fixed point of stepping
  p_lock_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && state_q == LOCK_STATE) |=> state_q == LOCK_STATE);

endmodule

// File: tb/lfsr_rev_counter_tb.sv
`timescale 1ns/1ps
module lfsr_rev_counter_tb;

  localparam logic [15:0] SEED    = 16'hACE1;
  localparam logic [15:0] F_MASK  = 16'h100B; // bits 12,3,1,0
  localparam logic [15:0] R_MASK  = 16'h8805; // bits 15,11,2,0
  localparam int          N_TRIP  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable_i = 1'b0;
  logic        dir_i = 1'b1;
  logic        load_i = 1'b0;
  logic [15:0] load_val_i = '0;
  logic [15:0] st_x;
  logic [15:0] st_n;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_x;
  logic [15:0] exp_n;

  always #2.5 clk = ~clk;

  lfsr_rev_counter #(.INVERT(1'b0), .SEED(SEED)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .dir_i(dir_i),
    .load_i(load_i), .load_val_i(load_val_i), .state_o(st_x)
  );

  lfsr_rev_counter #(.INVERT(1'b1), .SEED(SEED)) u_dut_xn (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .dir_i(dir_i),
    .load_i(load_i), .load_val_i(load_val_i), .state_o(st_n)
  );

  function automatic logic [15:0] m_fwd(logic [15:0] s, logic inv);
    return {(^(s & F_MASK)) ^ inv, s[15:1]};
  endfunction

  function automatic logic [15:0] m_rev(logic [15:0] s, logic inv);
    return {s[14:0], (^(s & R_MASK)) ^ inv};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample at the next falling edge
  task automatic tick(logic en, logic dir, logic ld, logic [15:0] val);
    enable_i   = en;
    dir_i      = dir;
    load_i     = ld;
    load_val_i = val;
    @(posedge clk);
    @(negedge clk);
    if (ld) begin
      exp_x = val;
      exp_n = val;
    end else if (en) begin
      exp_x = dir ? m_fwd(exp_x, 1'b0) : m_rev(exp_x, 1'b0);
      exp_n = dir ? m_fwd(exp_n, 1'b1) : m_rev(exp_n, 1'b1);
    end
    enable_i = 1'b0;
    load_i   = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_x = SEED;
    exp_n = SEED;
    check("R1 xor", st_x, SEED);
    check("R1 xnor", st_n, SEED);
  endtask

  task automatic t_forward();
    for (int k = 0; k < 20; k++) begin
      tick(1'b1, 1'b1, 1'b0, '0);
      check("R4 forward", st_x, exp_x);
      check("R8 forward xnor", st_n, exp_n);
    end
  endtask

  task automatic t_reverse();
    for (int k = 0; k < 20; k++) begin
      tick(1'b1, 1'b0, 1'b0, '0);
      check("R5 reverse", st_x, exp_x);
      check("R8 reverse xnor", st_n, exp_n);
    end
  endtask

  task automatic t_hold();
    logic [15:0] keep_x;
    logic [15:0] keep_n;
    keep_x = st_x;
    keep_n = st_n;
    for (int k = 0; k < 6; k++) begin
      tick(1'b0, k[0], 1'b0, 16'hFFFF);
      check("R3 hold", st_x, keep_x);
      check("R3 hold xnor", st_n, keep_n);
    end
  endtask

  task automatic t_load();
    tick(1'b1, 1'b1, 1'b1, 16'h1234);
    check("R2 load over forward", st_x, 16'h1234);
    tick(1'b1, 1'b0, 1'b1, 16'hBEEF);
    check("R2 load over reverse", st_x, 16'hBEEF);
    check("R2 load xnor", st_n, 16'hBEEF);
    tick(1'b0, 1'b0, 1'b1, 16'h0F0F);
    check("R2 load while idle", st_x, 16'h0F0F);
  endtask

  task automatic t_roundtrip(logic [15:0] start);
    logic [15:0] rec_x [N_TRIP+1];
    logic [15:0] rec_n [N_TRIP+1];
    tick(1'b0, 1'b1, 1'b1, start);
    rec_x[0] = st_x;
    rec_n[0] = st_n;
    for (int k = 1; k <= N_TRIP; k++) begin
      tick(1'b1, 1'b1, 1'b0, '0);
      rec_x[k] = st_x;
      rec_n[k] = st_n;
    end
    check("R6 forward end", st_x, exp_x);
    for (int k = N_TRIP - 1; k >= 0; k--) begin
      tick(1'b1, 1'b0, 1'b0, '0);
      check("R6 walk back", st_x, rec_x[k]);
      check("R8 walk back xnor", st_n, rec_n[k]);
    end
  endtask

  task automatic t_dirswap();
    logic [15:0] orig;
    tick(1'b0, 1'b1, 1'b1, 16'h5A3C);
    orig = st_x;
    for (int k = 0; k < 8; k++) begin
      tick(1'b1, k[0], 1'b0, '0);
      check("R7 alternating", st_x, exp_x);
      if (k[0]) check("R7 back to origin", st_x, orig);
    end
    tick(1'b1, 1'b1, 1'b0, '0);
    tick(1'b1, 1'b1, 1'b0, '0);
    tick(1'b1, 1'b0, 1'b0, '0);
    check("R7 two up one down", st_x, m_fwd(orig, 1'b0));
  endtask

  task automatic t_lock();
    tick(1'b0, 1'b1, 1'b1, 16'h0000);
    for (int k = 0; k < 4; k++) begin
      tick(1'b1, k[1], 1'b0, '0);
      check("R9 xor lock sticks", st_x, 16'h0000);
      check("R8 xnor leaves zero", st_n, exp_n);
    end
    tick(1'b0, 1'b1, 1'b1, 16'hFFFF);
    for (int k = 0; k < 4; k++) begin
      tick(1'b1, k[0], 1'b0, '0);
      check("R9 xnor lock sticks", st_n, 16'hFFFF);
    end
    tick(1'b0, 1'b1, 1'b1, 16'h0001);
    for (int k = 0; k < 3000; k++) begin
      tick(1'b1, 1'b1, 1'b0, '0);
      if (st_x == 16'h0000) check("R9 no lock entry", st_x, 16'h0001);
      if (st_n == 16'hFFFF) check("R9 no lock entry xnor", st_n, 16'h0001);
    end
    check("R9 long run xor", st_x, exp_x);
    check("R9 long run xnor", st_n, exp_n);
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_forward();
    t_reverse();
    t_hold();
    t_load();
    t_roundtrip(16'hACE1);
    t_roundtrip(16'h8000);
    t_dirswap();
    t_lock();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule